// File: doc/BRIEF.md
# Hamming ECC syndrome checker and byte corrector

This block receives, for one 256-byte chunk of a flash page, the parity code calculated while the data streamed past and the parity code that was read back from the spare area. It forms the syndrome of the two, decides whether the chunk is clean, whether only the stored parity is damaged, whether exactly one data bit flipped, or whether the damage cannot be repaired, and for a single flipped data bit reports which byte and which bit are wrong.

The calculated code is delivered as two raw accumulator words and packed inside the block. The stored code arrives as three bytes. A 512-byte page is handled as two chunks checked one after another, and a page-level failure flag gathers both results. Each chunk keeps its last correction in a small table. Bytes of the page can then be streamed through a correction port, which flips the faulty bit of the matching byte and passes every other byte unchanged.

Top module: `ecc_chunk_checker`

## Requirements
- R1: The calculated code is packed as bits 9:0 = `calc_acc_a[9:0]` and bits 20:11 = `calc_acc_b[9:0]`, with bits 10 and 21 zero. The stored code is `stored_code[21:0]`, where byte 0 (least significant) occupies bits 7:0. Stored bits 23:22 are ignored.
- R2: A check taken on a clock edge where `in_valid` is high produces a one-cycle `res_valid` pulse two edges later. Results enter back to back with no gaps. `res_status`, `res_chunk`, `res_byte` and `res_bit` hold their values between results.
- R3: When the syndrome (calculated XOR stored) is zero, or either 22-bit code is all zero, `res_status` is 0 (clean).
- R4: When exactly one syndrome bit is set, `res_status` is 1 (parity damaged), and the check counts as a failure.
- R5: When exactly 11 syndrome bits are set and the XOR of both codes' low halves (bits 10:0) with both codes' high halves (bits 21:11) equals 0x7FF, `res_status` is 2 (fixable). In that case `res_bit` is syndrome bits 2:0 and `res_byte` is syndrome bits 10:3. For any other status both indices are 0.
- R6: Any other syndrome gives `res_status` 3 (broken), which counts as a failure.
- R7: `page_done` pulses with the result of the last chunk of a page. That is every result when `in_wide` is 0, and the chunk 1 result when `in_wide` is 1. `page_fail` is updated with every result. It equals the chunk's own failure on a page's first chunk, and the OR of that failure with the earlier value on chunk 1 of a wide page.
- R8: The correction port is registered. One edge after `fix_valid`, `fix_out` carries `fix_data` with bit `res_bit` inverted, provided the chunk selected by `fix_index[8]` holds a fixable entry whose byte equals `fix_index[7:0]`.
- R9: Any other byte presented to the correction port comes out unchanged. `fix_out` holds its value when `fix_valid` is low.
- R10: A chunk's correction entry is rewritten only by a result for that chunk. A byte corrected on the same edge as that result uses the entry as it stood before the result.
- R11: During and right after reset, `res_valid`, `page_done`, `page_fail` and `fix_out_valid` are low, and the correction table holds no fixable entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A chunk check is presented |
| in_wide | input | 1 | 1: page of two chunks, 0: single-chunk page |
| in_chunk | input | 1 | Chunk number within the page |
| calc_acc_a | input | 16 | First raw parity accumulator word |
| calc_acc_b | input | 16 | Second raw parity accumulator word |
| stored_code | input | 24 | Stored code bytes, least significant byte in bits 7:0 |
| res_valid | output | 1 | Result strobe |
| res_status | output | 2 | 0 clean, 1 parity damaged, 2 fixable, 3 broken |
| res_chunk | output | 1 | Chunk the result belongs to |
| res_byte | output | 8 | Failing byte index within the chunk |
| res_bit | output | 3 | Failing bit index within the byte |
| page_fail | output | 1 | Accumulated failure of the page |
| page_done | output | 1 | Last chunk of the page has been reported |
| fix_valid | input | 1 | A data byte is offered for correction |
| fix_index | input | 9 | Byte position in the page (bit 8 = chunk) |
| fix_data | input | 8 | Data byte to correct |
| fix_out_valid | output | 1 | Corrected byte strobe |
| fix_out | output | 8 | Corrected byte |

## Verification
A check result that rewrites a chunk's correction entry can land on the same edge as a byte of that chunk entering the correction port. The bench provokes this in two ways. It offers a correction byte in the very cycle the new check is presented, and it offers one in the cycle the result appears. The behavioural model applies the old entry to the byte corrected on the updating edge and the new entry from the next edge on. Every cycle, every output is compared against the model, so a table that updates early or late shows up as a wrong bit in `fix_out`.

// File: rtl/ecc_chk_pkg.sv
package ecc_chk_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN    = 2'd0,
    ST_CODE_ERR = 2'd1,
    ST_FIXABLE  = 2'd2,
    ST_BROKEN   = 2'd3
  } ecc_status_e;

  function automatic logic status_fails(ecc_status_e s);
    return (s == ST_CODE_ERR) || (s == ST_BROKEN);
  endfunction
endpackage

// File: rtl/ecc_syndrome_classify.sv
module ecc_syndrome_classify
  import ecc_chk_pkg::*;
#(
  parameter int HALF_W = 11,
  parameter int BIT_W  = 3
) (
  input  logic [2*HALF_W-1:0]     calc_code,
  input  logic [2*HALF_W-1:0]     stored_code,
  output ecc_status_e             status,
  output logic [HALF_W-BIT_W-1:0] byte_idx,
  output logic [BIT_W-1:0]        bit_idx
);
  localparam int CODE_W = 2 * HALF_W;
  localparam int CNT_W  = $clog2(CODE_W + 1);
  localparam logic [CNT_W-1:0] ONES_SINGLE = CNT_W'(1);
  localparam logic [CNT_W-1:0] ONES_FIX    = CNT_W'(HALF_W);

  logic [CODE_W-1:0] syn;
  logic [CNT_W-1:0]  ones;
  logic [HALF_W-1:0] fold;

  always_comb begin
    syn  = calc_code ^ stored_code;
    ones = '0;
    for (int i = 0; i < CODE_W; i++) ones = ones + CNT_W'(syn[i]);
    fold = calc_code[HALF_W-1:0] ^ calc_code[CODE_W-1:HALF_W] ^
           stored_code[HALF_W-1:0] ^ stored_code[CODE_W-1:HALF_W];
    if (syn == '0 || calc_code == '0 || stored_code == '0) status = ST_CLEAN;
    else if (ones == ONES_SINGLE)                          status = ST_CODE_ERR;
    else if (ones == ONES_FIX && fold == '1)               status = ST_FIXABLE;
    else                                                   status = ST_BROKEN;
    byte_idx = (status == ST_FIXABLE) ? syn[HALF_W-1:BIT_W] : '0;
    bit_idx  = (status == ST_FIXABLE) ? syn[BIT_W-1:0]      : '0;
  end
endmodule

// File: rtl/ecc_fix_table.sv
module ecc_fix_table #(
  parameter int NUM_CHUNKS = 2,
  parameter int CHUNK_W    = 1,
  parameter int BYTE_W     = 8,
  parameter int BIT_W      = 3,
  parameter int DATA_W     = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      upd_valid,
  input  logic [CHUNK_W-1:0]        upd_chunk,
  input  logic                      upd_fixable,
  input  logic [BYTE_W-1:0]         upd_byte,
  input  logic [BIT_W-1:0]          upd_bit,
  input  logic                      fix_valid,
  input  logic [CHUNK_W+BYTE_W-1:0] fix_index,
  input  logic [DATA_W-1:0]         fix_data,
  output logic                      fix_out_valid,
  output logic [DATA_W-1:0]         fix_out
);
  logic              ent_ok   [NUM_CHUNKS];
  logic [BYTE_W-1:0] ent_byte [NUM_CHUNKS];
  logic [BIT_W-1:0]  ent_bit  [NUM_CHUNKS];

  for (genvar g = 0; g < NUM_CHUNKS; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_ok[g]   <= 1'b0;
        ent_byte[g] <= '0;
        ent_bit[g]  <= '0;
      end else if (upd_valid && upd_chunk == CHUNK_W'(g)) begin
        ent_ok[g]   <= upd_fixable;
        ent_byte[g] <= upd_byte;
        ent_bit[g]  <= upd_bit;
      end
    end
  end

  logic [CHUNK_W-1:0] sel;
  logic [DATA_W-1:0]  flip;

  always_comb begin
    sel  = fix_index[BYTE_W +: CHUNK_W];
    flip = '0;
    for (int c = 0; c < NUM_CHUNKS; c++) begin
      if (sel == CHUNK_W'(c) && ent_ok[c] && ent_byte[c] == fix_index[BYTE_W-1:0])
        flip = DATA_W'(1) << ent_bit[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fix_out_valid <= 1'b0;
      fix_out       <= '0;
    end else begin
      fix_out_valid <= fix_valid;
      if (fix_valid) fix_out <= fix_data ^ flip;
    end
  end

  assert_single_flip_R8: assert property (@(posedge clk) disable iff (rst)
    fix_out_valid |-> ($countones(fix_out ^ $past(fix_data)) <= 1));
  assert_table_empty_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (fix_out == $past(fix_data) || !fix_out_valid));
endmodule

// File: rtl/ecc_chunk_checker.sv
module ecc_chunk_checker
  import ecc_chk_pkg::*;
#(
  parameter int HALF_W     = 11,
  parameter int ACC_W      = 16,
  parameter int ACC_KEEP   = 10,
  parameter int NUM_CHUNKS = 2,
  parameter int DATA_W     = 8
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         in_valid,
  input  logic                                         in_wide,
  input  logic [((NUM_CHUNKS>1)?$clog2(NUM_CHUNKS):1)-1:0] in_chunk,
  input  logic [ACC_W-1:0]                             calc_acc_a,
  input  logic [ACC_W-1:0]                             calc_acc_b,
  input  logic [8*((2*HALF_W+7)/8)-1:0]                stored_code,
  output logic                                         res_valid,
  output logic [1:0]                                   res_status,
  output logic [((NUM_CHUNKS>1)?$clog2(NUM_CHUNKS):1)-1:0] res_chunk,
  output logic [HALF_W-$clog2(DATA_W)-1:0]             res_byte,
  output logic [$clog2(DATA_W)-1:0]                    res_bit,
  output logic                                         page_fail,
  output logic                                         page_done,
  input  logic                                         fix_valid,
  input  logic [((NUM_CHUNKS>1)?$clog2(NUM_CHUNKS):1)+HALF_W-$clog2(DATA_W)-1:0] fix_index,
  input  logic [DATA_W-1:0]                            fix_data,
  output logic                                         fix_out_valid,
  output logic [DATA_W-1:0]                            fix_out
);
  localparam int CODE_W  = 2 * HALF_W;
  localparam int BIT_W   = $clog2(DATA_W);
  localparam int BYTE_W  = HALF_W - BIT_W;
  localparam int CHUNK_W = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1;
  localparam logic [CHUNK_W-1:0] LAST_CHUNK = CHUNK_W'(NUM_CHUNKS - 1);

  // Code packing from the raw accumulators
  logic [CODE_W-1:0] calc_packed;
  always_comb begin
    calc_packed = '0;
    calc_packed[ACC_KEEP-1:0]        = calc_acc_a[ACC_KEEP-1:0];
    calc_packed[HALF_W +: ACC_KEEP]  = calc_acc_b[ACC_KEEP-1:0];
  end

  // Stage 1: input capture
  logic               s1_valid, s1_wide;
  logic [CHUNK_W-1:0] s1_chunk;
  logic [CODE_W-1:0]  s1_calc, s1_stored;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_wide   <= 1'b0;
      s1_chunk  <= '0;
      s1_calc   <= '0;
      s1_stored <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_wide   <= in_wide;
        s1_chunk  <= in_chunk;
        s1_calc   <= calc_packed;
        s1_stored <= stored_code[CODE_W-1:0];
      end
    end
  end

  // Stage 2: classification and result registers
  ecc_status_e       cls_status;
  logic [BYTE_W-1:0] cls_byte;
  logic [BIT_W-1:0]  cls_bit;

  ecc_syndrome_classify #(.HALF_W(HALF_W), .BIT_W(BIT_W)) u_classify (
    .calc_code   (s1_calc),
    .stored_code (s1_stored),
    .status      (cls_status),
    .byte_idx    (cls_byte),
    .bit_idx     (cls_bit)
  );

  logic first_of_page, last_of_page;
  assign first_of_page = !s1_wide || (s1_chunk == '0);
  assign last_of_page  = !s1_wide || (s1_chunk == LAST_CHUNK);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_status <= ST_CLEAN;
      res_chunk  <= '0;
      res_byte   <= '0;
      res_bit    <= '0;
      page_fail  <= 1'b0;
      page_done  <= 1'b0;
    end else begin
      res_valid <= s1_valid;
      page_done <= s1_valid && last_of_page;
      if (s1_valid) begin
        res_status <= cls_status;
        res_chunk  <= s1_chunk;
        res_byte   <= cls_byte;
        res_bit    <= cls_bit;
        page_fail  <= (first_of_page ? 1'b0 : page_fail) | status_fails(cls_status);
      end
    end
  end

  // Correction table and byte port
  ecc_fix_table #(
    .NUM_CHUNKS (NUM_CHUNKS),
    .CHUNK_W    (CHUNK_W),
    .BYTE_W     (BYTE_W),
    .BIT_W      (BIT_W),
    .DATA_W     (DATA_W)
  ) u_fix_table (
    .clk           (clk),
    .rst           (rst),
    .upd_valid     (s1_valid),
    .upd_chunk     (s1_chunk),
    .upd_fixable   (cls_status == ST_FIXABLE),
    .upd_byte      (cls_byte),
    .upd_bit       (cls_bit),
    .fix_valid     (fix_valid),
    .fix_index     (fix_index),
    .fix_data      (fix_data),
    .fix_out_valid (fix_out_valid),
    .fix_out       (fix_out)
  );

  assert_idx_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_status != ST_FIXABLE) |-> (res_byte == '0 && res_bit == '0));
  assert_fail_latched_R7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && (res_status == ST_CODE_ERR || res_status == ST_BROKEN)) |-> page_fail);
  assert_done_with_result_R7: assert property (@(posedge clk) disable iff (rst)
    page_done |-> res_valid);
  assert_quiet_after_reset_R11: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!res_valid && !page_done && !page_fail && !fix_out_valid));
  assert_result_follows_input_R2: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(s1_valid));
endmodule

// File: tb/ecc_chunk_checker_bench.sv
`timescale 1ns/1ps
module ecc_chunk_checker_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_wide = 1'b0;
  logic [0:0]  in_chunk = '0;
  logic [15:0] calc_acc_a = '0, calc_acc_b = '0;
  logic [23:0] stored_code = '0;
  logic        res_valid;
  logic [1:0]  res_status;
  logic [0:0]  res_chunk;
  logic [7:0]  res_byte;
  logic [2:0]  res_bit;
  logic        page_fail, page_done;
  logic        fix_valid = 1'b0;
  logic [8:0]  fix_index = '0;
  logic [7:0]  fix_data = '0;
  logic        fix_out_valid;
  logic [7:0]  fix_out;

  always #2.5 clk = ~clk;

  ecc_chunk_checker u_ecc_chunk_checker (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_wide(in_wide), .in_chunk(in_chunk),
    .calc_acc_a(calc_acc_a), .calc_acc_b(calc_acc_b), .stored_code(stored_code),
    .res_valid(res_valid), .res_status(res_status), .res_chunk(res_chunk),
    .res_byte(res_byte), .res_bit(res_bit), .page_fail(page_fail), .page_done(page_done),
    .fix_valid(fix_valid), .fix_index(fix_index), .fix_data(fix_data),
    .fix_out_valid(fix_out_valid), .fix_out(fix_out)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Behavioural model state
  bit      m_s1_v, m_s1_wide, m_s1_chunk;
  int unsigned m_s1_calc, m_s1_stored;
  bit      e_rv, e_pf, e_pd, e_fv, e_chunk;
  int      e_status, e_byte, e_bit;
  int      e_fo;
  bit      e_flip;
  bit      t_ok [2];
  int      t_byte [2], t_bit [2];

  function automatic int unsigned pack_code(int unsigned a, int unsigned b);
    return ((b % 1024) * 2048) + (a % 1024);
  endfunction

  function automatic string status_tag(int s);
    case (s)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic classify(int unsigned c, int unsigned s, output int st, output int by, output int bt);
    int unsigned syn, lo_fold;
    int cnt;
    syn = c ^ s;
    cnt = 0;
    for (int i = 0; i < 22; i++) if (syn[i]) cnt++;
    lo_fold = ((c % 2048) ^ (c / 2048)) ^ ((s % 2048) ^ (s / 2048));
    by = 0; bt = 0;
    if (syn == 0 || c == 0 || s == 0) st = 0;
    else if (cnt == 1) st = 1;
    else if (cnt == 11 && lo_fold == 2047) begin
      st = 2; by = (syn % 2048) / 8; bt = syn % 8;
    end else st = 3;
  endtask

  // One clock of stimulus, model update, and full comparison
  task automatic cyc(bit iv, bit wide, bit chunk, int unsigned a, int unsigned b,
                     int unsigned st, bit fv, int fi, int fd);
    int cs, cb, ct;
    in_valid = iv; in_wide = wide; in_chunk = chunk;
    calc_acc_a = a[15:0]; calc_acc_b = b[15:0]; stored_code = st[23:0];
    fix_valid = fv; fix_index = fi[8:0]; fix_data = fd[7:0];
    // correction port sees the table as it stands before this edge
    e_fv = fv;
    e_flip = 0;
    if (fv) begin
      e_fo = fd;
      if (t_ok[fi / 256] && t_byte[fi / 256] == fi % 256) begin
        e_fo = fd ^ (1 << t_bit[fi / 256]);
        e_flip = 1;
      end
    end
    e_rv = m_s1_v;
    e_pd = 0;
    if (m_s1_v) begin
      classify(m_s1_calc, m_s1_stored, cs, cb, ct);
      e_status = cs; e_byte = cb; e_bit = ct; e_chunk = m_s1_chunk;
      e_pf = ((!m_s1_wide || m_s1_chunk == 0) ? 1'b0 : e_pf) | (cs == 1 || cs == 3);
      e_pd = !m_s1_wide || m_s1_chunk == 1;
      t_ok[m_s1_chunk] = (cs == 2); t_byte[m_s1_chunk] = cb; t_bit[m_s1_chunk] = ct;
    end
    m_s1_v = iv;
    if (iv) begin
      m_s1_wide = wide; m_s1_chunk = chunk;
      m_s1_calc = pack_code(a, b); m_s1_stored = st % (1 << 22);
    end
    @(posedge clk);
    @(negedge clk);
    chk("R2", "res_valid", res_valid, e_rv);
    if (e_rv) begin
      chk(status_tag(e_status), "res_status", res_status, e_status);
      chk("R5", "res_byte", res_byte, e_byte);
      chk("R5", "res_bit", res_bit, e_bit);
      chk("R2", "res_chunk", res_chunk, e_chunk);
    end
    chk("R7", "page_fail", page_fail, e_pf);
    chk("R7", "page_done", page_done, e_pd);
    chk("R8", "fix_out_valid", fix_out_valid, e_fv);
    if (e_fv) chk(e_flip ? "R8" : "R9", "fix_out", fix_out, e_fo);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic check_code(bit wide, bit chunk, int unsigned a, int unsigned b, int unsigned mask);
    cyc(1, wide, chunk, a, b, pack_code(a, b) ^ mask, 0, 0, 0);
  endtask

  task automatic fix(int fi, int fd);
    cyc(0, 0, 0, 0, 0, 0, 1, fi, fd);
  endtask

  function automatic int unsigned fixable_mask(int by, int bt);
    int unsigned idx;
    idx = by * 8 + bt;
    return ((~idx & 2047) * 2048) | idx;
  endfunction

  initial begin
    for (int i = 0; i < 2; i++) begin t_ok[i] = 0; t_byte[i] = 0; t_bit[i] = 0; end
    e_rv = 0; e_pf = 0; e_pd = 0; e_fv = 0; e_fo = 0; e_status = 0; e_byte = 0; e_bit = 0; e_chunk = 0;
    m_s1_v = 0; m_s1_wide = 0; m_s1_chunk = 0; m_s1_calc = 0; m_s1_stored = 0;
    repeat (3) @(negedge clk);
    chk("R11", "res_valid in reset", res_valid, 0);
    chk("R11", "page_fail in reset", page_fail, 0);
    chk("R11", "page_done in reset", page_done, 0);
    chk("R11", "fix_out_valid in reset", fix_out_valid, 0);
    rst = 0;
    idle(1);
    // R11: table empty after reset, byte passes through
    fix(9'h000, 8'hA5);
    chk("R11", "fix_out after reset", fix_out, 8'hA5);

    // R3 clean match
    check_code(0, 0, 16'h1234, 16'hABCD, 0);
    idle(2);
    // R1: bits above the kept 10 are dropped, so this calc code packs to zero -> clean
    cyc(1, 0, 0, 16'hFC00, 16'hFC00, 24'h00_5A5A, 0, 0, 0);
    idle(1);
    chk("R1", "zero packed calc is clean", res_status, 0);
    // R1: stored bits 23:22 ignored
    cyc(1, 0, 0, 16'h0155, 16'h02AA, pack_code(16'h0155, 16'h02AA) | 24'hC00000, 0, 0, 0);
    idle(1);
    chk("R1", "stored top bits ignored", res_status, 0);
    // R3: stored all zero
    cyc(1, 0, 0, 16'h0077, 16'h0011, 0, 0, 0, 0);
    idle(2);
    // R4: one flipped parity bit
    check_code(0, 0, 16'h0321, 16'h0123, 24'h000020);
    idle(2);
    // R5: fixable in chunk 0, byte 0x5A bit 3
    check_code(0, 0, 16'h02F0, 16'h010F, fixable_mask(8'h5A, 3));
    idle(1);
    chk("R5", "byte index", res_byte, 8'h5A);
    fix(9'h05A, 8'hFF);
    chk("R8", "flip byte 0x5A bit3", fix_out, 8'hF7);
    fix(9'h05B, 8'hFF);
    chk("R9", "neighbour byte untouched", fix_out, 8'hFF);
    fix(9'h15A, 8'h3C);
    chk("R9", "other chunk untouched", fix_out, 8'h3C);
    // R6: two flipped bits; 11 bits without complement
    check_code(0, 1, 16'h0201, 16'h0102, 24'h000081);
    check_code(0, 1, 16'h0201, 16'h0102, 24'h000BFF);
    idle(2);
    chk("R6", "eleven bits not complementary", res_status, 3);
    // R10: chunk 1 result did not disturb chunk 0 entry
    fix(9'h05A, 8'h08);
    chk("R10", "chunk0 entry kept", fix_out, 8'h00);

    // R7: wide page, chunk 0 parity damaged, chunk 1 clean -> page fails
    check_code(1, 0, 16'h0101, 16'h0202, 24'h000400);
    check_code(1, 1, 16'h0303, 16'h0044, 0);
    idle(1);
    chk("R7", "first chunk fail held", page_fail, 1);
    idle(1);
    chk("R7", "page fail ORed", page_fail, 1);
    // wide page, clean then fixable -> page passes
    check_code(1, 0, 16'h0111, 16'h0222, 0);
    check_code(1, 1, 16'h03F0, 16'h000F, fixable_mask(8'h00, 0));
    idle(2);
    chk("R7", "fixable page passes", page_fail, 0);
    fix(9'h100, 8'h10);
    chk("R8", "chunk1 byte0 bit0", fix_out, 8'h11);

    // Collision cases for R10: chunk 0 fixable at byte 0xFF bit 7
    check_code(1, 0, 16'h0055, 16'h00AA, fixable_mask(8'hFF, 7));
    idle(2);
    // new clean check for chunk 0 presented with a matching byte: old entry applies
    cyc(1, 0, 0, 16'h0123, 16'h0321, pack_code(16'h0123, 16'h0321), 1, 9'h0FF, 8'h00);
    chk("R10", "byte with new input uses old entry", fix_out, 8'h80);
    fix(9'h0FF, 8'h00);
    chk("R10", "byte on updating edge uses old entry", fix_out, 8'h80);
    fix(9'h0FF, 8'h00);
    chk("R10", "entry cleared after clean result", fix_out, 8'h00);

    // back-to-back checks with corrections in between
    for (int k = 0; k < 24; k++) begin
      int unsigned a, b, m;
      a = (k * 16'h1F3 + 7) % 65536;
      b = (k * 16'h2B9 + 3) % 65536;
      case (k % 4)
        0: m = 0;
        1: m = fixable_mask((k * 37) % 256, k % 8);
        2: m = 1 << (k % 22);
        default: m = 24'h000003 << (k % 10);
      endcase
      cyc(1, k % 2, (k / 2) % 2, a, b, pack_code(a, b) ^ m, 1, (k * 37) % 512, k * 11 % 256);
    end
    idle(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule